// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block models a single-port synchronous static memory holding 18-bit words. Each word is split into two 9-bit lanes (eight data bits plus one parity bit), and a lane is always written as a whole. Every control and address input is sampled on the rising clock edge. Three chip selects qualify each access. Two address strobes open an access: one meant for a processor and one meant for a cache controller. An advance input then steps or holds the burst address, and a global-write input, a lane-write enable and per-lane selects choose between reading and writing.

A burst covers four words. The low two address bits come from a counter that counts either linearly or in the exclusive-or (interleaved) order, as chosen by a mode input. Read data passes through a registered pipeline and appears one clock edge after its address is sampled. It is presented on a separate output word together with a drive flag, which stands in for a tri-state bus. An asynchronous output enable gates that drive flag. A sleep input blocks all access. The array is a small parameterised stand-in for the real memory.

Top module: `burstSram`

## Requirements
- R1: Lane 0 is bits 8:0 and lane 1 is bits 17:9. When `allWrN` is low, a write cycle stores all 18 bits and the lane inputs are ignored. When `allWrN` is high, lane i is written only if `laneWrEnN` is low and `laneSelN[i]` is low. With `allWrN` high and `laneWrEnN` high, or with no lane selected, the cycle is a read.
- R2: When `procStrbN` and `ctrlStrbN` are both low, only the processor strobe is acted on. The cycle is therefore a read, and the write inputs are ignored.
- R3: `procStrbN` is ignored while `sel0N` is high. The cycle then behaves as if that strobe were high: a running burst goes on, or a low `ctrlStrbN` is taken as a controller strobe.
- R4: The block is selected only when `sel0N` is low, `sel1` is high and `sel2N` is low. A recognised strobe sampled while the block is not selected performs no access and ends the burst, so later strobe-free cycles neither read nor write.
- R5: A processor-strobe access reads in its first cycle and ignores the write inputs and `advN` there. A write from it happens on the next edge, using the write inputs sampled at that edge, at the same address when `advN` is high.
- R6: A controller-strobe access, with `procStrbN` high, writes in the same cycle at the presented address when the write inputs call for a write.
- R7: In a strobe-free cycle of a running burst, a low `advN` accesses the next burst address. With `seqMode` = 0 the low two bits are the start bits plus the step count, modulo 4. With `seqMode` = 1 they are the start bits XOR the step count. The sequence wraps after four steps.
- R8: In a strobe-free cycle of a running burst, a high `advN` accesses the current burst address again, for reads and for writes.
- R9: A read whose address is sampled at edge t shows its data with `dataOe` high after edge t+1. The cycle right after a select from the deselected state is undriven.
- R10: `dataOe` follows `outEnN` asynchronously for read data. The output slot that belongs to a write cycle is never driven, whatever `outEnN` is.
- R11: After a deselecting edge or an edge taken with `sleep` high, `dataOe` is low at once. Read data still in flight is dropped.
- R12: While `sleep` is high, no access is accepted and the memory does not change. A running burst is dropped.
- R13: After reset, `dataOe` is low and no burst is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sel0N | input | 1 | Active-low select; also qualifies the processor strobe |
| sel1 | input | 1 | Active-high select |
| sel2N | input | 1 | Active-low select |
| procStrbN | input | 1 | Active-low processor address strobe |
| ctrlStrbN | input | 1 | Active-low controller address strobe |
| advN | input | 1 | Active-low burst advance |
| allWrN | input | 1 | Active-low global write |
| laneWrEnN | input | 1 | Active-low lane-write enable |
| laneSelN | input | 2 | Active-low per-lane write selects |
| outEnN | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Blocks all access while high |
| seqMode | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| dataIn | input | 18 | Write data |
| dataOut | output | 18 | Read data, zero when not driven |
| dataOe | output | 1 | Read data is being driven |

## Verification
Two functions collide in a single cycle when both strobes are low together. The bench then has to see a processor-style read rather than a controller write. It provokes this with `allWrN` low and all-ones write data on a word whose content it knows, and judges the result by reading that word back unchanged. A second collision happens when the processor strobe arrives while `sel0N` is high, during a running read burst. The bench counts the test as passed if the output keeps being driven, which shows the burst went on and was not deselected. Together with a second case where both strobes are low and `sel0N` is high, which must deselect, this separates the masking rule from the priority rule.

// File: rtl/burstSramPkg.sv
`timescale 1ns/1ps
package burstSramPkg;
  localparam int LANE_CNT = 2;

  typedef struct packed {
    logic                rdEn;
    logic [LANE_CNT-1:0] laneWr;
    logic                flush;
  } accCmdT;
endpackage

// File: rtl/burstSramCtrl.sv
`timescale 1ns/1ps
module burstSramCtrl
  import burstSramPkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sel0N,
  input  logic                sel1,
  input  logic                sel2N,
  input  logic                procStrbN,
  input  logic                ctrlStrbN,
  input  logic                advN,
  input  logic                allWrN,
  input  logic                laneWrEnN,
  input  logic [LANE_CNT-1:0] laneSelN,
  input  logic                sleep,
  input  logic                seqMode,
  input  logic [ADDR_W-1:0]   addr,
  output accCmdT              cmd,
  output logic [ADDR_W-1:0]   accAddr
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic                burstOn;
  logic [ADDR_W-1:0]   baseAddr;
  logic [BURST_W-1:0]  step;
  logic [BURST_W-1:0]  useStep;
  logic [BURST_W-1:0]  lowBits;
  logic [LANE_CNT-1:0] laneMask;
  logic chipSel, procGo, ctrlGo, startHit, dropHit, contHit;

  always_comb begin
    chipSel  = !sel0N && sel1 && !sel2N;
    procGo   = !procStrbN && !sel0N && !sleep;
    ctrlGo   = !ctrlStrbN && !procGo && !sleep;
    startHit = (procGo || ctrlGo) && chipSel;
    dropHit  = ((procGo || ctrlGo) && !chipSel) || sleep;
    contHit  = !procGo && !ctrlGo && burstOn && !sleep;
  end

  always_comb begin
    if (!allWrN)         laneMask = '1;
    else if (!laneWrEnN) laneMask = ~laneSelN;
    else                 laneMask = '0;
  end

  always_comb begin
    useStep = advN ? step : step + BURST_W'(1);
    if (seqMode) lowBits = baseAddr[BURST_W-1:0] ^ useStep;
    else         lowBits = baseAddr[BURST_W-1:0] + useStep;
  end

  always_comb begin
    cmd     = '0;
    accAddr = addr;
    if (startHit) begin
      accAddr    = addr;
      cmd.laneWr = ctrlGo ? laneMask : '0;
      cmd.rdEn   = !ctrlGo || (laneMask == '0);
    end else if (contHit) begin
      accAddr    = {baseAddr[ADDR_W-1:BURST_W], lowBits};
      cmd.laneWr = laneMask;
      cmd.rdEn   = (laneMask == '0);
    end
    cmd.flush = dropHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstOn  <= 1'b0;
      baseAddr <= '0;
      step     <= '0;
    end else if (startHit) begin
      burstOn  <= 1'b1;
      baseAddr <= addr;
      step     <= '0;
    end else if (dropHit) begin
      burstOn  <= 1'b0;
    end else if (contHit && !advN) begin
      step     <= step + BURST_W'(1);
    end
  end

  // R5: the opening cycle of a processor-strobe access never writes
  assert_proc_first_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrbN && !sel0N && !sleep) |-> (cmd.laneWr == '0));

  // R4: a recognised strobe while unselected makes no access
  assert_unsel_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((!ctrlStrbN || (!procStrbN && !sel0N)) && !(!sel0N && sel1 && !sel2N))
      |-> (!cmd.rdEn && cmd.laneWr == '0));

  // R12: sleep blocks every access
  assert_sleep_R12: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> (!cmd.rdEn && cmd.laneWr == '0));

  // R8: a suspended strobe-free burst keeps the address of the previous cycle
  assert_suspend_R8: assert property (@(posedge clk) disable iff (!rstN)
    (contHit && advN && $past(cmd.rdEn || cmd.laneWr != '0) && $past(!cmd.flush))
      |-> (accAddr == $past(accAddr)));

  // R1: a global write stores every lane
  assert_global_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!allWrN && contHit) |-> (cmd.laneWr == '1));
endmodule

// File: rtl/burstSramData.sv
`timescale 1ns/1ps
module burstSramData
  import burstSramPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  accCmdT                     cmd,
  input  logic [ADDR_W-1:0]          accAddr,
  input  logic [LANE_CNT*LANE_W-1:0] dataIn,
  input  logic                       outEnN,
  output logic [LANE_CNT*LANE_W-1:0] dataOut,
  output logic                       dataOe
);
  localparam int DATA_W = LANE_CNT * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [ADDR_W-1:0] rdAddr;
  logic              rdValid;
  logic              outValid;
  logic [DATA_W-1:0] outWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      rdValid  <= cmd.flush ? 1'b0 : cmd.rdEn;
      outValid <= cmd.flush ? 1'b0 : rdValid;
    end
  end

  always_ff @(posedge clk) begin
    if (cmd.rdEn) rdAddr <= accAddr;
  end

  for (genvar g = 0; g < LANE_CNT; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] laneOut;

    always_ff @(posedge clk) begin
      if (cmd.laneWr[g]) laneMem[accAddr] <= dataIn[g*LANE_W +: LANE_W];
      laneOut <= laneMem[rdAddr];
    end

    assign outWord[g*LANE_W +: LANE_W] = laneOut;
  end

  always_comb begin
    dataOe  = outValid && !outEnN;
    dataOut = dataOe ? outWord : '0;
  end

  // R11: a flushing edge leaves the output undriven
  assert_flush_R11: assert property (@(posedge clk) disable iff (!rstN)
    cmd.flush |=> !outValid);

  // R10: the slot of a pure write cycle is never driven
  assert_wrslot_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.laneWr != '0 && !cmd.flush) |=> ##1 !outValid);

  // R9: valid output always stems from a read one edge earlier
  assert_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(rdValid));

  // R10: drive only with the enable low
  assert_oe_R10: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> !outEnN);
endmodule

// File: rtl/burstSram.sv
`timescale 1ns/1ps
module burstSram
  import burstSramPkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2,
  localparam int DATA_W = LANE_CNT * LANE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sel0N,
  input  logic                sel1,
  input  logic                sel2N,
  input  logic                procStrbN,
  input  logic                ctrlStrbN,
  input  logic                advN,
  input  logic                allWrN,
  input  logic                laneWrEnN,
  input  logic [LANE_CNT-1:0] laneSelN,
  input  logic                outEnN,
  input  logic                sleep,
  input  logic                seqMode,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   dataIn,
  output logic [DATA_W-1:0]   dataOut,
  output logic                dataOe
);
  accCmdT            cmd;
  logic [ADDR_W-1:0] accAddr;

  burstSramCtrl #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sel0N(sel0N), .sel1(sel1), .sel2N(sel2N),
    .procStrbN(procStrbN), .ctrlStrbN(ctrlStrbN), .advN(advN),
    .allWrN(allWrN), .laneWrEnN(laneWrEnN), .laneSelN(laneSelN),
    .sleep(sleep), .seqMode(seqMode), .addr(addr),
    .cmd(cmd), .accAddr(accAddr)
  );

  burstSramData #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) uData (
    .clk(clk), .rstN(rstN), .cmd(cmd), .accAddr(accAddr),
    .dataIn(dataIn), .outEnN(outEnN), .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: tb/burstSram_test.sv
`timescale 1ns/1ps
module burstSram_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sel0N = 1'b0, sel1 = 1'b1, sel2N = 1'b0;
  logic procStrbN = 1'b1, ctrlStrbN = 1'b1, advN = 1'b1;
  logic allWrN = 1'b1, laneWrEnN = 1'b1;
  logic [1:0] laneSelN = 2'b11;
  logic outEnN = 1'b0, sleep = 1'b0, seqMode = 1'b0;
  logic [5:0] addr = '0;
  logic [17:0] dataIn = '0;
  logic [17:0] dataOut;
  logic dataOe;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  burstSram uut (
    .clk(clk), .rstN(rstN), .sel0N(sel0N), .sel1(sel1), .sel2N(sel2N),
    .procStrbN(procStrbN), .ctrlStrbN(ctrlStrbN), .advN(advN),
    .allWrN(allWrN), .laneWrEnN(laneWrEnN), .laneSelN(laneSelN),
    .outEnN(outEnN), .sleep(sleep), .seqMode(seqMode), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );

  function automatic logic [17:0] pv(int a);
    return 18'((a * 7919) ^ 18'h2D3C1);
  endfunction

  task automatic chk(string tag, logic [17:0] act, logic [17:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idleIn();
    sel0N = 1'b0; sel1 = 1'b1; sel2N = 1'b0;
    procStrbN = 1'b1; ctrlStrbN = 1'b1; advN = 1'b1;
    allWrN = 1'b1; laneWrEnN = 1'b1; laneSelN = 2'b11;
    sleep = 1'b0; outEnN = 1'b0;
  endtask

  task automatic ctrlWr(int a, logic [17:0] d);
    idleIn(); ctrlStrbN = 1'b0; addr = 6'(a); dataIn = d; allWrN = 1'b0;
    tick(); idleIn();
  endtask

  task automatic desel();
    idleIn(); ctrlStrbN = 1'b0; sel1 = 1'b0;
    tick(); idleIn();
  endtask

  task automatic rdChk(int a, logic [17:0] exp, string tag);
    idleIn(); ctrlStrbN = 1'b0; addr = 6'(a);
    tick(); idleIn();
    tick();
    chk({tag, " oe"}, 18'(dataOe), 18'd1);
    chk(tag, dataOut, exp);
  endtask

  task automatic testReset();
    chk("R13 oe after reset", 18'(dataOe), 18'd0);
    tick();
    chk("R13 no burst after reset", 18'(dataOe), 18'd0);
  endtask

  task automatic testLatency();
    ctrlWr(5, 18'h2A5A5);
    desel();
    ctrlStrbN = 1'b0; addr = 6'd5;
    tick(); idleIn();
    chk("R9 first cycle undriven", 18'(dataOe), 18'd0);
    tick();
    chk("R9 data after second edge", dataOut, 18'h2A5A5);
    chk("R6 one-cycle write visible", 18'(dataOe), 18'd1);
    desel();
  endtask

  task automatic testLanes();
    ctrlWr(6, 18'h3FFFF);
    idleIn(); ctrlStrbN = 1'b0; addr = 6'd6; dataIn = '0;
    laneWrEnN = 1'b0; laneSelN = 2'b10;
    tick(); desel();
    rdChk(6, 18'h3FE00, "R1 lane0 only");
    desel();
    idleIn(); ctrlStrbN = 1'b0; addr = 6'd6; dataIn = '0; laneSelN = 2'b00;
    tick(); desel();
    rdChk(6, 18'h3FE00, "R1 lane enable high no write");
    desel();
    idleIn(); ctrlStrbN = 1'b0; addr = 6'd6; dataIn = 18'h12345;
    allWrN = 1'b0; laneWrEnN = 1'b1; laneSelN = 2'b11;
    tick(); desel();
    rdChk(6, 18'h12345, "R1 global overrides");
    desel();
  endtask

  task automatic testPriority();
    ctrlWr(7, 18'h0AAAA);
    desel();
    procStrbN = 1'b0; ctrlStrbN = 1'b0; addr = 6'd7;
    allWrN = 1'b0; dataIn = 18'h3FFFF;
    tick(); idleIn();
    tick();
    chk("R2 both strobes read data", dataOut, 18'h0AAAA);
    desel();
    rdChk(7, 18'h0AAAA, "R2 no write happened");
    desel();
  endtask

  task automatic testMask();
    ctrlWr(8, pv(8));
    desel();
    rdChk(8, pv(8), "R3 setup read");
    sel0N = 1'b1; procStrbN = 1'b0;
    tick(); idleIn();
    chk("R3 masked strobe keeps burst", 18'(dataOe), 18'd1);
    tick();
    chk("R3 burst still reads", dataOut, pv(8));
    sel0N = 1'b1; procStrbN = 1'b0; ctrlStrbN = 1'b0;
    tick(); idleIn();
    chk("R3 controller strobe deselects", 18'(dataOe), 18'd0);
    desel();
  endtask

  task automatic testDeselect();
    ctrlWr(10, pv(10));
    ctrlWr(11, pv(11));
    ctrlWr(12, pv(12));
    desel();
    ctrlStrbN = 1'b0; addr = 6'd10;
    tick(); idleIn();
    tick();
    chk("R4 setup driven", 18'(dataOe), 18'd1);
    ctrlStrbN = 1'b0; sel1 = 1'b0;
    tick(); idleIn();
    chk("R11 undriven at once", 18'(dataOe), 18'd0);
    allWrN = 1'b0; dataIn = '0; advN = 1'b0;
    tick();
    tick();
    chk("R4 no access after deselect", 18'(dataOe), 18'd0);
    idleIn(); ctrlStrbN = 1'b0; sel2N = 1'b1; addr = 6'd12;
    allWrN = 1'b0; dataIn = '0;
    tick(); idleIn();
    rdChk(10, pv(10), "R4 addr10 untouched");
    desel();
    rdChk(11, pv(11), "R4 addr11 untouched");
    desel();
    rdChk(12, pv(12), "R4 sel2N high no write");
    desel();
  endtask

  task automatic testProcWrite();
    logic [17:0] oldV = 18'h1F0F0;
    logic [17:0] d = 18'h00155;
    ctrlWr(20, oldV);
    desel();
    procStrbN = 1'b0; addr = 6'd20; allWrN = 1'b0; dataIn = 18'h3FFFF;
    tick(); idleIn();
    laneWrEnN = 1'b0; laneSelN = 2'b10; dataIn = d; advN = 1'b1;
    tick();
    desel();
    rdChk(20, {oldV[17:9], d[8:0]}, "R5 second edge lane write");
    desel();
  endtask

  task automatic burstRun(bit mode, int start, int ord0, int ord1, int ord2, int ord3, string tag);
    seqMode = mode;
    idleIn(); ctrlStrbN = 1'b0; addr = 6'(start);
    tick(); idleIn(); advN = 1'b0;
    tick(); chk({tag, " beat0"}, dataOut, pv(ord0));
    tick(); chk({tag, " beat1"}, dataOut, pv(ord1));
    tick(); chk({tag, " beat2"}, dataOut, pv(ord2));
    tick(); idleIn(); chk({tag, " beat3"}, dataOut, pv(ord3));
    tick(); chk({tag, " wrap"}, dataOut, pv(ord0));
    desel();
    seqMode = 1'b0;
  endtask

  task automatic testBursts();
    for (int i = 32; i < 36; i++) ctrlWr(i, pv(i));
    desel();
    burstRun(1'b0, 34, 34, 35, 32, 33, "R7 linear");
    burstRun(1'b1, 33, 33, 32, 35, 34, "R7 interleaved");
  endtask

  task automatic testSuspend();
    for (int i = 40; i < 46; i++) ctrlWr(i, pv(i));
    desel();
    ctrlStrbN = 1'b0; addr = 6'd40;
    tick(); idleIn();
    tick(); chk("R8 read hold a", dataOut, pv(40));
    tick(); chk("R8 read hold b", dataOut, pv(40));
    advN = 1'b0;
    tick(); idleIn(); chk("R8 read hold c", dataOut, pv(40));
    tick(); chk("R8 then advance", dataOut, pv(41));
    desel();
    ctrlStrbN = 1'b0; addr = 6'd44; allWrN = 1'b0; dataIn = 18'h01111;
    tick(); idleIn();
    allWrN = 1'b0; dataIn = 18'h02222;
    tick(); desel();
    rdChk(44, 18'h02222, "R8 write repeats address");
    desel();
    rdChk(45, pv(45), "R8 next address untouched");
    desel();
  endtask

  task automatic testOutEnable();
    ctrlWr(50, pv(50));
    desel();
    ctrlStrbN = 1'b0; addr = 6'd50;
    tick(); idleIn(); outEnN = 1'b1;
    tick();
    chk("R10 enable high undriven", 18'(dataOe), 18'd0);
    outEnN = 1'b0;
    #1;
    chk("R10 async enable drives", dataOut, pv(50));
    desel();
    ctrlStrbN = 1'b0; addr = 6'd51; allWrN = 1'b0; dataIn = pv(51);
    tick(); idleIn(); ctrlStrbN = 1'b0; addr = 6'd51; allWrN = 1'b0;
    tick(); idleIn();
    chk("R10 write slot undriven", 18'(dataOe), 18'd0);
    desel();
  endtask

  task automatic testSleep();
    ctrlWr(52, pv(52));
    ctrlWr(53, pv(53));
    desel();
    ctrlStrbN = 1'b0; addr = 6'd52;
    tick(); idleIn();
    tick();
    chk("R12 setup driven", 18'(dataOe), 18'd1);
    sleep = 1'b1; ctrlStrbN = 1'b0; addr = 6'd53; allWrN = 1'b0; dataIn = '0;
    tick();
    chk("R11 sleep undriven at once", 18'(dataOe), 18'd0);
    idleIn();
    tick();
    tick();
    chk("R12 burst dropped", 18'(dataOe), 18'd0);
    rdChk(53, pv(53), "R12 memory unchanged");
    desel();
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    rstN = 1'b1;
    tick();
    testReset();
    testLatency();
    testLanes();
    testPriority();
    testMask();
    testDeselect();
    testProcWrite();
    testBursts();
    testSuspend();
    testOutEnable();
    testSleep();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule